// File: doc/BRIEF.md
# Real-Time Clock Register File with Interrupt Status

This block is the host-facing side of a real-time clock. Software reaches it through two byte-wide I/O locations. An access with address bit 0 low loads a 7-bit register index. An access with address bit 0 high reads or writes the byte at that index. The 128-byte space holds several kinds of byte:

- the current time: seconds, minutes, hours, weekday, day of month, month and year;
- three alarm bytes;
- four control and status registers;
- general-purpose storage.

A neighbouring time-keeping block supplies the new time fields and a one-second update strobe. A rate divider supplies a periodic tick. This block loads the time bytes on each update unless software has frozen updates. It then compares the alarm bytes against the refreshed time and collects interrupt flags in a status register. It drives a level interrupt request until software reads that status register, and the read clears it.

Register indices are fixed because software decodes them:

| Index | Contents |
|-------|----------|
| 0 | seconds |
| 1 | seconds alarm |
| 2 | minutes |
| 3 | minutes alarm |
| 4 | hours |
| 5 | hours alarm |
| 6 | weekday |
| 7 | day of month |
| 8 | month |
| 9 | year |
| 10 | control A |
| 11 | control B |
| 12 | status C |
| 13 | status D |
| 14 to 127 | general storage |

Top module: `rtc_regfile_irq`

## Requirements
- R1: A write with bus_addr=0 loads the index register with bits 6:0 of the data and ignores bit 7. A read with bus_addr=0 returns 0xFF.
- R2: Indices 0 to 9 and 14 to 127 are plain bytes. A write with bus_addr=1 stores the data at the current index, and a later read with bus_addr=1 returns it.
- R3: After reset the control and status registers read as follows, and irq is low:
  - control A (index 10) reads 0x26;
  - control B (index 11) reads 0x02;
  - status C (index 12) reads 0x00;
  - status D (index 13) reads 0x80.
- R4: Bit 7 of control A is the update-in-progress flag, and software cannot write it. A write to A stores bits 6:0 only, and bit 7 keeps its current value.
- R5: Writes to status C and status D have no effect on what those registers read.
- R6: A sec_tick while the freeze bit is 0 has two effects. At the next edge, indices 0, 2, 4, 6, 7, 8 and 9 take now_sec, now_min, now_hour, now_wday, now_mday, now_mon and now_year. The update-in-progress flag (A bit 7) reads 1 for exactly the one cycle that follows, then reads 0 again.
- R7: Control B bit 7 is the freeze bit. While it is 1, a sec_tick changes no time byte and sets no flag. A write to B with bit 7 set forces the update-in-progress flag to 0.
- R8: One cycle after the time bytes load, status C bit 4 (update-ended) becomes 1. If B bit 4 (update interrupt enable) is set, C bit 7 also becomes 1 and irq goes high.
- R9: At that same point, if B bit 5 (alarm interrupt enable) is set and all three alarm bytes match, C bits 7 and 5 become 1. An alarm byte matches when its top two bits are both 1, or when it equals the corresponding time byte (index 0, 2 or 4).
- R10: A per_tick with B bit 6 (periodic interrupt enable) set makes C bits 7 and 6 become 1 at the next edge. With that enable clear, a per_tick sets no flag.
- R11: A read of status C returns its current value, and at the same edge C clears to 0 and irq drops. A flag raised by an event in that same cycle is kept.
- R12: irq is high exactly while C bit 7 is 1. Once raised, it stays high until software reads C.
- R13: sqw_pulse is high in a cycle exactly when per_tick is high and B bit 3 (square-wave enable) is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 1 | 0 = index location, 1 = data location |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address and index (combinational) |
| sec_tick | input | 1 | One-second update strobe |
| per_tick | input | 1 | Periodic-rate tick |
| now_sec | input | 8 | Seconds from the time-keeping block, already in register encoding |
| now_min | input | 8 | Minutes |
| now_hour | input | 8 | Hours |
| now_wday | input | 8 | Weekday |
| now_mday | input | 8 | Day of month |
| now_mon | input | 8 | Month |
| now_year | input | 8 | Year |
| irq | output | 1 | Level interrupt request |
| sqw_pulse | output | 1 | Square-wave pulse, one cycle wide |

## Verification
The assertions watch the following on every cycle:
- irq stays high until a status read;
- a status read with no competing event leaves C at zero;
- the freeze bit holds the update-in-progress flag low and stops the seconds byte from moving;
- the update-in-progress flag lasts a single cycle;
- each completed update, alarm with all bytes set to don't-care, and enabled periodic tick raises its flag.

Some behaviour only the bench scenarios can show:
- read values after reset;
- that bit 7 of control A cannot be written;
- that writes to C and D have no effect;
- alarm comparison against exact time bytes, on both a match and a miss;
- a status read that collides with a periodic tick.

The bench's reference model checks those by comparing read data, irq and sqw_pulse against its own expectations.

// File: rtl/rtc_rf_pkg.sv
package rtc_rf_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // Fixed register indices; software decodes these.
    localparam int IX_SEC   = 0;
    localparam int IX_ASEC  = 1;
    localparam int IX_MIN   = 2;
    localparam int IX_AMIN  = 3;
    localparam int IX_HOUR  = 4;
    localparam int IX_AHOUR = 5;
    localparam int IX_WDAY  = 6;
    localparam int IX_MDAY  = 7;
    localparam int IX_MON   = 8;
    localparam int IX_YEAR  = 9;
    localparam int IX_CTLA  = 10;
    localparam int IX_CTLB  = 11;
    localparam int IX_STAT  = 12;
    localparam int IX_VALID = 13;

    // Control B layout, bit 7 down to bit 0.
    typedef struct packed {
        logic freeze;
        logic per_en;
        logic alm_en;
        logic upd_en;
        logic sqw_en;
        logic bin_mode;
        logic h24;
        logic spare;
    } ctlb_t;

    // Status C flag masks.
    localparam byte_t ST_IRQF = 8'h80;
    localparam byte_t ST_PER  = 8'h40;
    localparam byte_t ST_ALM  = 8'h20;
    localparam byte_t ST_UPD  = 8'h10;

    localparam logic [6:0] CTLA_RESET  = 7'h26;
    localparam byte_t      CTLB_RESET  = 8'h02;
    localparam byte_t      VALID_VALUE = 8'h80;
    localparam byte_t      IDX_READ    = 8'hFF;

    typedef struct packed {
        byte_t sec;
        byte_t min;
        byte_t hour;
        byte_t wday;
        byte_t mday;
        byte_t mon;
        byte_t year;
    } time_t;

    // An alarm byte with both top bits set matches any value.
    function automatic logic alarm_hit(byte_t alm, byte_t cur);
        return (alm[7:6] == 2'b11) || (alm == cur);
    endfunction

endpackage

// File: rtl/rtc_rf_index.sv
module rtc_rf_index #(
    parameter int IDX_W = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  rtc_rf_pkg::byte_t  wdata,
    output logic [IDX_W-1:0]   idx
);
    always_ff @(posedge clk) begin
        if (rst)
            idx <= '0;
        else if (load)
            idx <= wdata[IDX_W-1:0];
    end
endmodule

// File: rtl/rtc_rf_store.sv
module rtc_rf_store
    import rtc_rf_pkg::*;
#(
    parameter int NUM_REGS = 128,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  byte_t            wdata,
    input  logic             load_time,
    input  time_t            now,
    output byte_t            rd_byte,
    output byte_t            cur_sec,
    output byte_t            cur_min,
    output byte_t            cur_hour,
    output byte_t            alm_sec,
    output byte_t            alm_min,
    output byte_t            alm_hour
);
    byte_t mem [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++)
                mem[i] <= '0;
        end else begin
            if (load_time) begin
                mem[IX_SEC]  <= now.sec;
                mem[IX_MIN]  <= now.min;
                mem[IX_HOUR] <= now.hour;
                mem[IX_WDAY] <= now.wday;
                mem[IX_MDAY] <= now.mday;
                mem[IX_MON]  <= now.mon;
                mem[IX_YEAR] <= now.year;
            end
            // A bus write to the same byte in the same cycle wins.
            if (wr_en)
                mem[idx] <= wdata;
        end
    end

    assign rd_byte  = mem[idx];
    assign cur_sec  = mem[IX_SEC];
    assign cur_min  = mem[IX_MIN];
    assign cur_hour = mem[IX_HOUR];
    assign alm_sec  = mem[IX_ASEC];
    assign alm_min  = mem[IX_AMIN];
    assign alm_hour = mem[IX_AHOUR];
endmodule

// File: rtl/rtc_rf_ctrl.sv
module rtc_rf_ctrl
    import rtc_rf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_a,
    input  logic  wr_b,
    input  byte_t wdata,
    input  logic  sec_tick,
    output byte_t a_byte,
    output ctlb_t ctlb,
    output logic  uip,
    output logic  load_time,
    output logic  done_fire
);
    logic [6:0] a_low;
    logic       done_q;

    assign load_time = sec_tick & ~ctlb.freeze;
    assign done_fire = done_q & ~ctlb.freeze;
    assign a_byte    = {uip, a_low};

    always_ff @(posedge clk) begin
        if (rst) begin
            a_low  <= CTLA_RESET;
            ctlb   <= ctlb_t'(CTLB_RESET);
            uip    <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= load_time;
            if (wr_a)
                a_low <= wdata[6:0];
            if (wr_b)
                ctlb <= ctlb_t'(wdata);
            if (wr_b && wdata[7])
                uip <= 1'b0;
            else if (load_time)
                uip <= 1'b1;
            else if (done_q)
                uip <= 1'b0;
        end
    end
endmodule

// File: rtl/rtc_rf_irq.sv
module rtc_rf_irq
    import rtc_rf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  per_tick,
    input  logic  done_fire,
    input  logic  clr,
    input  ctlb_t ctlb,
    input  byte_t cur_sec,
    input  byte_t cur_min,
    input  byte_t cur_hour,
    input  byte_t alm_sec,
    input  byte_t alm_min,
    input  byte_t alm_hour,
    output byte_t stat,
    output logic  irq,
    output logic  sqw_pulse
);
    logic  hit;
    byte_t raise;

    assign hit = alarm_hit(alm_sec, cur_sec) &&
                 alarm_hit(alm_min, cur_min) &&
                 alarm_hit(alm_hour, cur_hour);

    always_comb begin
        raise = '0;
        if (per_tick && ctlb.per_en)
            raise = raise | ST_IRQF | ST_PER;
        if (done_fire) begin
            raise = raise | ST_UPD;
            if (ctlb.upd_en)
                raise = raise | ST_IRQF;
            if (ctlb.alm_en && hit)
                raise = raise | ST_IRQF | ST_ALM;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            stat <= '0;
        else
            stat <= (clr ? '0 : stat) | raise;
    end

    assign irq       = stat[7];
    assign sqw_pulse = per_tick & ctlb.sqw_en;
endmodule

// File: rtl/rtc_regfile_irq.sv
module rtc_regfile_irq
    import rtc_rf_pkg::*;
#(
    parameter int NUM_REGS = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_en,
    input  logic       bus_we,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       sec_tick,
    input  logic       per_tick,
    input  logic [7:0] now_sec,
    input  logic [7:0] now_min,
    input  logic [7:0] now_hour,
    input  logic [7:0] now_wday,
    input  logic [7:0] now_mday,
    input  logic [7:0] now_mon,
    input  logic [7:0] now_year,
    output logic       irq,
    output logic       sqw_pulse
);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic [IDX_W-1:0] cur_idx;
    logic             wr_idx, wr_dat, rd_dat;
    logic             is_a, is_b, is_c, is_d;
    logic             wr_a, wr_b, store_we, clr_stat;
    logic             load_time, done_fire, uip;
    byte_t            a_byte, st_byte, stat_bits, b_bits, tm_sec_q;
    byte_t            cur_min, cur_hour, alm_sec, alm_min, alm_hour;
    ctlb_t            ctlb;
    time_t            now;

    assign now = '{sec: now_sec, min: now_min, hour: now_hour, wday: now_wday,
                   mday: now_mday, mon: now_mon, year: now_year};

    assign wr_idx   = bus_en & bus_we & ~bus_addr;
    assign wr_dat   = bus_en & bus_we & bus_addr;
    assign rd_dat   = bus_en & ~bus_we & bus_addr;
    assign is_a     = (cur_idx == IDX_W'(IX_CTLA));
    assign is_b     = (cur_idx == IDX_W'(IX_CTLB));
    assign is_c     = (cur_idx == IDX_W'(IX_STAT));
    assign is_d     = (cur_idx == IDX_W'(IX_VALID));
    assign wr_a     = wr_dat & is_a;
    assign wr_b     = wr_dat & is_b;
    assign store_we = wr_dat & ~(is_a | is_b | is_c | is_d);
    assign clr_stat = rd_dat & is_c;
    assign b_bits   = byte_t'(ctlb);

    rtc_rf_index #(.IDX_W(IDX_W)) u_index (
        .clk   (clk),
        .rst   (rst),
        .load  (wr_idx),
        .wdata (bus_wdata),
        .idx   (cur_idx)
    );

    rtc_rf_store #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (store_we),
        .idx       (cur_idx),
        .wdata     (bus_wdata),
        .load_time (load_time),
        .now       (now),
        .rd_byte   (st_byte),
        .cur_sec   (tm_sec_q),
        .cur_min   (cur_min),
        .cur_hour  (cur_hour),
        .alm_sec   (alm_sec),
        .alm_min   (alm_min),
        .alm_hour  (alm_hour)
    );

    rtc_rf_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_a      (wr_a),
        .wr_b      (wr_b),
        .wdata     (bus_wdata),
        .sec_tick  (sec_tick),
        .a_byte    (a_byte),
        .ctlb      (ctlb),
        .uip       (uip),
        .load_time (load_time),
        .done_fire (done_fire)
    );

    rtc_rf_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .per_tick  (per_tick),
        .done_fire (done_fire),
        .clr       (clr_stat),
        .ctlb      (ctlb),
        .cur_sec   (tm_sec_q),
        .cur_min   (cur_min),
        .cur_hour  (cur_hour),
        .alm_sec   (alm_sec),
        .alm_min   (alm_min),
        .alm_hour  (alm_hour),
        .stat      (stat_bits),
        .irq       (irq),
        .sqw_pulse (sqw_pulse)
    );

    always_comb begin
        if (!bus_addr)
            bus_rdata = IDX_READ;
        else if (is_a)
            bus_rdata = a_byte;
        else if (is_b)
            bus_rdata = b_bits;
        else if (is_c)
            bus_rdata = stat_bits;
        else if (is_d)
            bus_rdata = VALID_VALUE;
        else
            bus_rdata = st_byte;
    end
endmodule

// File: rtl/rtc_rf_checker.sv
module rtc_rf_checker (
    input logic       clk,
    input logic       rst,
    input logic       rd_dat,
    input logic       is_c,
    input logic       wr_dat,
    input logic       sec_tick,
    input logic       per_tick,
    input logic       done_fire,
    input logic       uip,
    input logic       irq,
    input logic       sqw_pulse,
    input logic [7:0] b_bits,
    input logic [7:0] stat_bits,
    input logic [7:0] tm_sec_q,
    input logic [7:0] alm_sec,
    input logic [7:0] alm_min,
    input logic [7:0] alm_hour
);
    logic c_rd, all_dc;
    assign c_rd   = rd_dat & is_c;
    assign all_dc = (alm_sec[7:6] == 2'b11) && (alm_min[7:6] == 2'b11) &&
                    (alm_hour[7:6] == 2'b11);

    assert_irq_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (irq && !c_rd) |=> irq);

    assert_stat_clear_R11: assert property (@(posedge clk) disable iff (rst)
        (c_rd && !per_tick && !done_fire) |=> (stat_bits == 8'h00 && !irq));

    assert_freeze_no_uip_R7: assert property (@(posedge clk) disable iff (rst)
        b_bits[7] |-> !uip);

    assert_freeze_time_R7: assert property (@(posedge clk) disable iff (rst)
        (b_bits[7] && !wr_dat) |=> $stable(tm_sec_q));

    assert_uip_single_R6: assert property (@(posedge clk) disable iff (rst)
        (uip && !sec_tick) |=> !uip);

    assert_update_flag_R8: assert property (@(posedge clk) disable iff (rst)
        done_fire |=> stat_bits[4]);

    assert_alarm_dc_R9: assert property (@(posedge clk) disable iff (rst)
        (done_fire && b_bits[5] && all_dc) |=> (stat_bits[7] && stat_bits[5]));

    assert_periodic_R10: assert property (@(posedge clk) disable iff (rst)
        (per_tick && b_bits[6]) |=> (stat_bits[6] && irq));

    assert_sqw_src_R13: assert property (@(posedge clk) disable iff (rst)
        sqw_pulse |-> per_tick);
endmodule

bind rtc_regfile_irq rtc_rf_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_dat    (rd_dat),
    .is_c      (is_c),
    .wr_dat    (wr_dat),
    .sec_tick  (sec_tick),
    .per_tick  (per_tick),
    .done_fire (done_fire),
    .uip       (uip),
    .irq       (irq),
    .sqw_pulse (sqw_pulse),
    .b_bits    (b_bits),
    .stat_bits (stat_bits),
    .tm_sec_q  (tm_sec_q),
    .alm_sec   (alm_sec),
    .alm_min   (alm_min),
    .alm_hour  (alm_hour)
);

// File: tb/rtc_regfile_irq_tb.sv
module rtc_regfile_irq_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_en = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sec_tick = 1'b0, per_tick = 1'b0;
    logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_wday = '0;
    logic [7:0] now_mday = '0, now_mon = '0, now_year = '0;
    logic       irq, sqw_pulse;

    int checks = 0;
    int errors = 0;

    // Reference model state
    int m_mem [128];
    int m_alow, m_b, m_c, m_uip, m_done, m_idx;

    always #4 clk = ~clk;

    rtc_regfile_irq u_dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sec_tick(sec_tick), .per_tick(per_tick),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
        .now_wday(now_wday), .now_mday(now_mday), .now_mon(now_mon),
        .now_year(now_year), .irq(irq), .sqw_pulse(sqw_pulse)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 128; i++) m_mem[i] = 0;
        m_alow = 'h26; m_b = 'h02; m_c = 0; m_uip = 0; m_done = 0; m_idx = 0;
    endtask

    function automatic int model_read(input int a);
        if (a == 0) return 'hFF;
        case (m_idx)
            10: return (m_uip << 7) | m_alow;
            11: return m_b;
            12: return m_c;
            13: return 'h80;
            default: return m_mem[m_idx];
        endcase
    endfunction

    function automatic bit amatch(input int alm, input int cur);
        return ((alm & 'hC0) == 'hC0) || (alm == cur);
    endfunction

    // One bus cycle; called just after a falling edge.
    task automatic step(input bit en, input bit we, input bit a, input int wd,
                        input bit sec, input bit per, input string tag);
        int  setb, sets;
        bit  frz, start, dfire, crd;
        bus_en = en; bus_we = we; bus_addr = a; bus_wdata = wd[7:0];
        sec_tick = sec; per_tick = per;
        #1;
        if (en && !we) check(tag, bus_rdata, model_read(a));
        check("R13 sqw_pulse", sqw_pulse, (per && m_b[3]) ? 1 : 0);
        @(posedge clk);
        frz   = m_b[7];
        start = sec && !frz;
        dfire = m_done && !frz;
        sets  = 0;
        if (per && m_b[6]) sets |= 'hC0;
        if (dfire) begin
            sets |= 'h10;
            if (m_b[4]) sets |= 'h80;
            if (m_b[5] && amatch(m_mem[1], m_mem[0]) && amatch(m_mem[3], m_mem[2])
                && amatch(m_mem[5], m_mem[4])) sets |= 'hA0;
        end
        crd  = en && !we && a && (m_idx == 12);
        m_c  = (crd ? 0 : m_c) | sets;
        setb = (en && we && a && m_idx == 11 && wd[7]) ? 1 : 0;
        if (setb) m_uip = 0;
        else if (start) m_uip = 1;
        else if (m_done) m_uip = 0;
        m_done = start;
        if (start) begin
            m_mem[0] = now_sec;  m_mem[2] = now_min; m_mem[4] = now_hour;
            m_mem[6] = now_wday; m_mem[7] = now_mday; m_mem[8] = now_mon;
            m_mem[9] = now_year;
        end
        if (en && we) begin
            if (!a) m_idx = wd & 'h7F;
            else case (m_idx)
                10: m_alow = wd & 'h7F;
                11: m_b = wd & 'hFF;
                12, 13: ;
                default: m_mem[m_idx] = wd & 'hFF;
            endcase
        end
        @(negedge clk);
        check("R12 irq level", irq, (m_c >> 7) & 1);
        bus_en = 0; bus_we = 0; sec_tick = 0; per_tick = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 1, 0, 0, 0, "idle");
    endtask

    task automatic wr_reg(input int ix, input int v);
        step(1, 1, 0, ix, 0, 0, "idx");
        step(1, 1, 1, v, 0, 0, "wr");
    endtask

    task automatic rd_reg(input int ix, input string tag);
        step(1, 1, 0, ix, 0, 0, "idx");
        step(1, 0, 1, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R3 reset values
        check("R3 irq after reset", irq, 0);
        rd_reg(10, "R3 ctl A reset");
        rd_reg(11, "R3 ctl B reset");
        rd_reg(12, "R3 stat C reset");
        rd_reg(13, "R3 stat D reset");
        // R1 index keeps 7 bits, even read gives 0xFF
        step(1, 1, 0, 'hFF, 0, 0, "idx");
        step(1, 1, 1, 'h5A, 0, 0, "wr");
        step(1, 0, 0, 0, 0, 0, "R1 even-address read");
        rd_reg(127, "R1 R2 byte at 0x7F");
        wr_reg(20, 'hA5);
        wr_reg(9, 'h33);
        rd_reg(20, "R2 storage byte");
        rd_reg(9, "R2 year byte");
        // R4 bit 7 of A read-only
        wr_reg(10, 'hFF);
        rd_reg(10, "R4 ctl A write");
        wr_reg(10, 'h26);
        // R5 C and D ignore writes
        wr_reg(12, 'hFF);
        rd_reg(12, "R5 stat C after write");
        wr_reg(13, 'h00);
        rd_reg(13, "R5 stat D after write");
        // R6 R8 R9 update with don't-care alarms
        wr_reg(1, 'hC0); wr_reg(3, 'hC3); wr_reg(5, 'hFF);
        wr_reg(11, 'h32);
        now_sec = 'h59; now_min = 'h30; now_hour = 'h12; now_wday = 'h03;
        now_mday = 'h15; now_mon = 'h06; now_year = 'h24;
        step(1, 1, 0, 10, 1, 0, "idx");
        step(1, 0, 1, 0, 0, 0, "R6 uip high");
        step(1, 0, 1, 0, 0, 0, "R6 uip low");
        idle(3);
        rd_reg(0, "R6 seconds loaded");
        rd_reg(4, "R6 hours loaded");
        rd_reg(8, "R6 month loaded");
        rd_reg(12, "R8 R9 stat after update");
        rd_reg(12, "R11 stat cleared");
        // R9 exact alarm match and miss
        wr_reg(1, 'h07); wr_reg(3, 'hC0); wr_reg(5, 'hC0);
        now_sec = 'h07;
        step(0, 0, 1, 0, 1, 0, "tick");
        idle(2);
        rd_reg(12, "R9 exact alarm hit");
        now_sec = 'h08;
        step(0, 0, 1, 0, 1, 0, "tick");
        idle(2);
        rd_reg(12, "R9 alarm miss");
        // R8 update without update enable
        wr_reg(11, 'h02);
        step(0, 0, 1, 0, 1, 0, "tick");
        idle(2);
        rd_reg(12, "R8 flag without irq");
        // R7 freeze mode
        wr_reg(11, 'h82);
        now_sec = 'h44;
        step(0, 0, 1, 0, 1, 0, "tick");
        idle(2);
        rd_reg(0, "R7 seconds frozen");
        rd_reg(12, "R7 no flag frozen");
        rd_reg(10, "R7 uip low frozen");
        wr_reg(11, 'h12);
        step(1, 1, 0, 11, 1, 0, "idx");
        step(1, 1, 1, 'h92, 0, 0, "R7 freeze during uip");
        rd_reg(10, "R7 uip cleared by freeze");
        rd_reg(12, "R7 stat after freeze");
        wr_reg(11, 'h02);
        // R10 R13 periodic
        step(0, 0, 1, 0, 0, 1, "per no enable");
        rd_reg(12, "R10 no flag without enable");
        wr_reg(11, 'h4A);
        step(0, 0, 1, 0, 0, 1, "per");
        idle(3);
        rd_reg(12, "R10 periodic flag");
        // R11 read colliding with tick
        step(1, 1, 0, 12, 0, 1, "idx+per");
        step(1, 0, 1, 0, 0, 1, "R11 read during tick");
        step(1, 0, 1, 0, 0, 0, "R11 kept new flag");
        step(1, 0, 1, 0, 0, 0, "R11 cleared");
        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule